// File: doc/BRIEF.md
# NVM Boot Load Sequencer

This block runs every time the chip wakes or is reset. It streams a fixed 64-byte setup area out of an 8 KB non-volatile memory into code/data RAM, and from that area it picks up the program level, the user image location and the user image length. When the part is programmed at user level, it then copies the user image into internal RAM and code/data RAM. Last, it writes a small block of boot variables at the top of code/data RAM.

After loading, the sequencer does one of two things. It can enable debug access and wait until software or a debug host sets a run-request bit. Or, when the persistent auto-run bit is set and the volatile trim override is clear, it releases the processor at once. The override bit is held in the sequencer's own flag register. Only a power-on reset clears it, and it wins over auto-run.

The NVM port uses synchronous reads: the address and read enable go out in one cycle and the data is valid on the following cycle. RAM writes use a single port, with a select line that chooses between code/data RAM and internal RAM.

Top module: `nvm_boot_seq`

## Requirements
- R1: While `por_n` is low, and for the two cycles after it rises, `run_rel`, `dbg_en`, `ram_we` and `nvm_re` are 0 and `flags_q` is 0.
- R2: A power-on reset or a one-cycle pulse on `evt_button`, `evt_timer` or `evt_host` starts a new boot, clears flag bits 0 and 1, and drops `run_rel` and `dbg_en`. The cause code is 0 for power-on, 1 for button, 2 for timer and 3 for host. When events arrive together, host beats timer and timer beats button.
- R3: Every boot first reads NVM addresses 0xFFC0 to 0xFFFF in rising order. Byte k is written to code/data RAM (`ram_sel`=0) at address 0xFE00+k.
- R4: Every boot ends its loading by writing four bytes to code/data RAM at 0xFFFC to 0xFFFF. In order these are: the first unread NVM address (low byte, then high byte), the program level byte, and the cause code.
- R5: If the level byte at setup offset 0x38 is 0x00, no user bytes are copied. The first unread address reported is the user start word, `dbg_en` rises and `run_rel` stays 0.
- R6: If the level byte is non-zero, the user image is copied. Its start address is the little-endian word at setup offsets 0x3A/0x3B and its length is the word at 0x3C/0x3D. Image byte i goes to internal RAM (`ram_sel`=1) at address i when i<16, and otherwise to code/data RAM at address i-16. The first unread address reported is start+length.
- R7: After a user copy with `autorun`=0, the sequencer waits with `dbg_en`=1 and `run_rel`=0.
- R8: After a user copy with `autorun`=1 and flag bit 2 clear, `run_rel` rises and `dbg_en` stays 0.
- R9: When flag bit 2 (trim override) is 1 at decision time, a user-level part behaves as a factory part: no user copy, `dbg_en`=1, no release, whatever the value of `autorun`.
- R10: Writing 1 to a flag bit sets it, and writing 0 has no effect. Bit 2 survives boot events and is cleared only by `por_n`.
- R11: While waiting, a set flag bit 0 or bit 1 makes `run_rel` rise one cycle after `flags_q` shows the bit. `run_rel` and `dbg_en` then stay high until the next boot event.
- R12: A boot event that arrives during loading abandons the load and restarts from R3. Only the restarted boot's writes follow.
- R13: A user length of zero copies nothing, and the first unread address reported equals the start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| evt_button | input | 1 | Button wake pulse |
| evt_timer | input | 1 | Sleep-timer wake pulse |
| evt_host | input | 1 | Debug-host reset pulse |
| autorun | input | 1 | Persistent auto-run bit from NVM protection |
| flags_we | input | 1 | Flag register write strobe (ones set bits) |
| flags_wdata | input | 3 | Flag write data: bit0 run request A, bit1 run request B, bit2 trim override |
| flags_q | output | 3 | Flag register contents |
| nvm_addr | output | 16 | NVM read address |
| nvm_re | output | 1 | NVM read enable |
| nvm_rdata | input | 8 | NVM read data, valid the cycle after `nvm_re` |
| ram_we | output | 1 | RAM write strobe |
| ram_sel | output | 1 | 0 selects code/data RAM, 1 selects internal RAM |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| dbg_en | output | 1 | Debug access enable |
| run_rel | output | 1 | Processor run release |

## Verification
Some properties are checked on every cycle. A held release only ends on a boot event. A waiting sequencer with a set run bit releases on the next cycle. Waiting and running states never touch NVM or RAM. Every boot event clears the run bits and the outputs. The trim bit never falls outside power-on reset. The bench scenarios cover the rest: the byte-exact contents of the setup copy, the user copy and the boot variable block, the address split between internal and code RAM, the priority of trim over auto-run, restart in the middle of a load, and the cause encoding when events arrive together.

// File: rtl/nvm_boot_pkg.sv
package nvm_boot_pkg;

  // Setup area layout (offsets inside the 64-byte area)
  localparam int          SETUP_BYTES  = 64;
  localparam logic [5:0]  OFS_LEVEL    = 6'h38;
  localparam logic [5:0]  OFS_START_LO = 6'h3A;
  localparam logic [5:0]  OFS_START_HI = 6'h3B;
  localparam logic [5:0]  OFS_LEN_LO   = 6'h3C;
  localparam logic [5:0]  OFS_LEN_HI   = 6'h3D;

  // Boot variable block size at the top of code/data RAM
  localparam int          BVAR_BYTES   = 4;

  // Flag register bit positions
  localparam int          FLG_RUN_A    = 0;
  localparam int          FLG_RUN_B    = 1;
  localparam int          FLG_TRIM     = 2;
  localparam int          FLG_W        = 3;

  typedef enum logic [2:0] {
    ST_START,
    ST_SETUP,
    ST_DECIDE,
    ST_USER,
    ST_BVAR,
    ST_WAIT,
    ST_RUN
  } boot_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'd0,
    CAUSE_BUTTON = 2'd1,
    CAUSE_TIMER  = 2'd2,
    CAUSE_HOST   = 2'd3
  } boot_cause_e;

endpackage

// File: rtl/boot_flag_reg.sv
module boot_flag_reg
  import nvm_boot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_evt,
  input  logic             we,
  input  logic [FLG_W-1:0] wdata,
  output logic [FLG_W-1:0] q,
  output logic             run_req,
  output logic             trim
);

  logic [FLG_W-1:0] q_r;
  logic [FLG_W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (boot_evt) begin
      q_n[FLG_RUN_A] = 1'b0;
      q_n[FLG_RUN_B] = 1'b0;
    end
    if (we) begin
      q_n = q_n | wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_n;
    end
  end

  assign q       = q_r;
  assign run_req = q_r[FLG_RUN_A] | q_r[FLG_RUN_B];
  assign trim    = q_r[FLG_TRIM];

endmodule

// File: rtl/nvm_stream.sv
module nvm_stream #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         start,
  input  logic [W-1:0] base,
  input  logic [W-1:0] len,
  output logic [W-1:0] rd_addr,
  output logic         rd_en,
  input  logic [7:0]   rd_data,
  output logic         out_vld,
  output logic [W-1:0] out_idx,
  output logic [7:0]   out_data,
  output logic         done
);

  logic [W-1:0] base_q, base_n;
  logic [W-1:0] len_q,  len_n;
  logic [W-1:0] cnt_q,  cnt_n;
  logic [W-1:0] idx_q,  idx_n;
  logic         busy_q, busy_n;
  logic         vld_q,  vld_n;
  logic         last_q, last_n;
  logic         zero_q, zero_n;
  logic         at_end;

  assign at_end = (cnt_q == len_q - W'(1));

  always_comb begin
    base_n = base_q;
    len_n  = len_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    idx_n  = cnt_q;
    vld_n  = busy_q;
    last_n = busy_q & at_end;
    zero_n = 1'b0;
    if (busy_q) begin
      cnt_n = cnt_q + W'(1);
      if (at_end) begin
        busy_n = 1'b0;
      end
    end
    if (start) begin
      base_n = base;
      len_n  = len;
      cnt_n  = '0;
      busy_n = (len != '0);
      zero_n = (len == '0);
    end
    if (abort) begin
      busy_n = 1'b0;
      vld_n  = 1'b0;
      last_n = 1'b0;
      zero_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      base_q <= base_n;
      len_q  <= len_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      busy_q <= busy_n;
      vld_q  <= vld_n;
      last_q <= last_n;
      zero_q <= zero_n;
    end
  end

  assign rd_en    = busy_q;
  assign rd_addr  = base_q + cnt_q;
  assign out_vld  = vld_q;
  assign out_idx  = idx_q;
  assign out_data = rd_data;
  assign done     = (vld_q & last_q) | zero_q;

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import nvm_boot_pkg::*;
#(
  parameter int                RAM_AW        = 16,
  parameter int                IRAM_LEN      = 16,
  parameter logic [15:0]       SETUP_BASE    = 16'hFFC0,
  parameter logic [RAM_AW-1:0] CFG_RAM_BASE  = RAM_AW'(16'hFE00),
  parameter logic [RAM_AW-1:0] USER_RAM_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_button,
  input  logic              evt_timer,
  input  logic              evt_host,
  input  logic              trim,
  input  logic              run_req,
  input  logic              autorun,
  input  logic              s_vld,
  input  logic [15:0]       s_idx,
  input  logic [7:0]        s_data,
  input  logic              s_done,
  output logic              s_start,
  output logic              s_abort,
  output logic [15:0]       s_base,
  output logic [15:0]       s_len,
  output logic              ram_we,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              boot_evt,
  output logic              dbg_en,
  output logic              run_rel
);

  localparam logic [RAM_AW-1:0] BVAR_BASE = RAM_AW'((1 << RAM_AW) - BVAR_BYTES);
  localparam logic [15:0]       IRAM_L16  = 16'(IRAM_LEN);

  boot_state_e state_q, state_n;
  boot_cause_e cause_q, cause_n;
  logic [7:0]  level_q, level_n;
  logic [15:0] ustart_q, ustart_n;
  logic [15:0] ulen_q, ulen_n;
  logic [15:0] unread_q, unread_n;
  logic        upath_q, upath_n;
  logic        dbg_q, dbg_n;
  logic [1:0]  bv_q, bv_n;
  logic        evt_any;
  logic        take_user;
  boot_cause_e evt_cause;

  assign evt_any   = evt_button | evt_timer | evt_host;
  assign take_user = !trim && (level_q != 8'h00);

  always_comb begin
    if (evt_host) begin
      evt_cause = CAUSE_HOST;
    end else if (evt_timer) begin
      evt_cause = CAUSE_TIMER;
    end else begin
      evt_cause = CAUSE_BUTTON;
    end
  end

  always_comb begin
    state_n   = state_q;
    cause_n   = cause_q;
    level_n   = level_q;
    ustart_n  = ustart_q;
    ulen_n    = ulen_q;
    unread_n  = unread_q;
    upath_n   = upath_q;
    dbg_n     = dbg_q;
    bv_n      = bv_q;
    s_start   = 1'b0;
    s_base    = '0;
    s_len     = '0;
    ram_we    = 1'b0;
    ram_sel   = 1'b0;
    ram_addr  = '0;
    ram_wdata = s_data;

    case (state_q)
      ST_START: begin
        s_start = 1'b1;
        s_base  = SETUP_BASE;
        s_len   = 16'(SETUP_BYTES);
        state_n = ST_SETUP;
      end

      ST_SETUP: begin
        if (s_vld) begin
          ram_we   = 1'b1;
          ram_addr = CFG_RAM_BASE + RAM_AW'(s_idx[5:0]);
          if (s_idx[5:0] == OFS_LEVEL)    level_n        = s_data;
          if (s_idx[5:0] == OFS_START_LO) ustart_n[7:0]  = s_data;
          if (s_idx[5:0] == OFS_START_HI) ustart_n[15:8] = s_data;
          if (s_idx[5:0] == OFS_LEN_LO)   ulen_n[7:0]    = s_data;
          if (s_idx[5:0] == OFS_LEN_HI)   ulen_n[15:8]   = s_data;
        end
        if (s_done) begin
          state_n = ST_DECIDE;
        end
      end

      ST_DECIDE: begin
        upath_n = take_user;
        bv_n    = 2'd0;
        if (take_user) begin
          s_start = 1'b1;
          s_base  = ustart_q;
          s_len   = ulen_q;
          state_n = ST_USER;
        end else begin
          unread_n = ustart_q;
          state_n  = ST_BVAR;
        end
      end

      ST_USER: begin
        if (s_vld) begin
          ram_we = 1'b1;
          if (s_idx < IRAM_L16) begin
            ram_sel  = 1'b1;
            ram_addr = RAM_AW'(s_idx);
          end else begin
            ram_addr = USER_RAM_BASE + RAM_AW'(s_idx - IRAM_L16);
          end
        end
        if (s_done) begin
          unread_n = ustart_q + ulen_q;
          state_n  = ST_BVAR;
        end
      end

      ST_BVAR: begin
        ram_we   = 1'b1;
        ram_addr = BVAR_BASE + RAM_AW'(bv_q);
        case (bv_q)
          2'd0:    ram_wdata = unread_q[7:0];
          2'd1:    ram_wdata = unread_q[15:8];
          2'd2:    ram_wdata = level_q;
          default: ram_wdata = {6'b0, cause_q};
        endcase
        bv_n = bv_q + 2'd1;
        if (bv_q == 2'd3) begin
          if (upath_q && autorun) begin
            state_n = ST_RUN;
          end else begin
            state_n = ST_WAIT;
            dbg_n   = 1'b1;
          end
        end
      end

      ST_WAIT: begin
        if (run_req) begin
          state_n = ST_RUN;
        end
      end

      ST_RUN: begin
        state_n = ST_RUN;
      end

      default: begin
        state_n = ST_START;
      end
    endcase

    // A boot event overrides whatever the current step was doing
    if (evt_any) begin
      state_n = ST_START;
      cause_n = evt_cause;
      dbg_n   = 1'b0;
      ram_we  = 1'b0;
      s_start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_START;
      cause_q  <= CAUSE_POR;
      level_q  <= '0;
      ustart_q <= '0;
      ulen_q   <= '0;
      unread_q <= '0;
      upath_q  <= 1'b0;
      dbg_q    <= 1'b0;
      bv_q     <= '0;
    end else begin
      state_q  <= state_n;
      cause_q  <= cause_n;
      level_q  <= level_n;
      ustart_q <= ustart_n;
      ulen_q   <= ulen_n;
      unread_q <= unread_n;
      upath_q  <= upath_n;
      dbg_q    <= dbg_n;
      bv_q     <= bv_n;
    end
  end

  assign s_abort  = evt_any;
  assign boot_evt = evt_any;
  assign dbg_en   = dbg_q;
  assign run_rel  = (state_q == ST_RUN);

endmodule

// File: rtl/nvm_boot_seq.sv
module nvm_boot_seq
  import nvm_boot_pkg::*;
#(
  parameter int                RAM_AW        = 16,
  parameter int                IRAM_LEN      = 16,
  parameter logic [15:0]       SETUP_BASE    = 16'hFFC0,
  parameter logic [RAM_AW-1:0] CFG_RAM_BASE  = RAM_AW'(16'hFE00),
  parameter logic [RAM_AW-1:0] USER_RAM_BASE = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              evt_button,
  input  logic              evt_timer,
  input  logic              evt_host,
  input  logic              autorun,
  input  logic              flags_we,
  input  logic [FLG_W-1:0]  flags_wdata,
  output logic [FLG_W-1:0]  flags_q,
  output logic [15:0]       nvm_addr,
  output logic              nvm_re,
  input  logic [7:0]        nvm_rdata,
  output logic              ram_we,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              dbg_en,
  output logic              run_rel
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic        boot_evt;
  logic        run_req;
  logic        trim;
  logic        s_start, s_abort, s_vld, s_done;
  logic [15:0] s_base, s_len, s_idx;
  logic [7:0]  s_data;

  boot_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_evt (boot_evt),
    .we       (flags_we),
    .wdata    (flags_wdata),
    .q        (flags_q),
    .run_req  (run_req),
    .trim     (trim)
  );

  nvm_stream #(.W(16)) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (s_abort),
    .start    (s_start),
    .base     (s_base),
    .len      (s_len),
    .rd_addr  (nvm_addr),
    .rd_en    (nvm_re),
    .rd_data  (nvm_rdata),
    .out_vld  (s_vld),
    .out_idx  (s_idx),
    .out_data (s_data),
    .done     (s_done)
  );

  boot_ctrl #(
    .RAM_AW        (RAM_AW),
    .IRAM_LEN      (IRAM_LEN),
    .SETUP_BASE    (SETUP_BASE),
    .CFG_RAM_BASE  (CFG_RAM_BASE),
    .USER_RAM_BASE (USER_RAM_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_button (evt_button),
    .evt_timer  (evt_timer),
    .evt_host   (evt_host),
    .trim       (trim),
    .run_req    (run_req),
    .autorun    (autorun),
    .s_vld      (s_vld),
    .s_idx      (s_idx),
    .s_data     (s_data),
    .s_done     (s_done),
    .s_start    (s_start),
    .s_abort    (s_abort),
    .s_base     (s_base),
    .s_len      (s_len),
    .ram_we     (ram_we),
    .ram_sel    (ram_sel),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .boot_evt   (boot_evt),
    .dbg_en     (dbg_en),
    .run_rel    (run_rel)
  );

endmodule

// File: rtl/nvm_boot_seq_chk.sv
module nvm_boot_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       evt_button,
  input logic       evt_timer,
  input logic       evt_host,
  input logic       flags_we,
  input logic [2:0] flags_q,
  input logic       nvm_re,
  input logic       ram_we,
  input logic       dbg_en,
  input logic       run_rel
);

  logic evt;
  assign evt = evt_button | evt_timer | evt_host;

  // R11: a granted release holds until a boot event
  assert_run_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
    (run_rel && !evt) |=> run_rel);

  // R11: waiting with a run bit set releases on the next cycle
  assert_wait_release_R11: assert property (@(posedge clk) disable iff (!por_n)
    (dbg_en && !run_rel && (flags_q[0] || flags_q[1]) && !evt) |=> run_rel);

  // R5, R7: the waiting sequencer touches neither memory
  assert_wait_quiet_R5: assert property (@(posedge clk) disable iff (!por_n)
    dbg_en |-> (!ram_we && !nvm_re));

  // R8: a released processor sees no further loading
  assert_run_quiet_R8: assert property (@(posedge clk) disable iff (!por_n)
    run_rel |-> (!ram_we && !nvm_re));

  // R2: every boot event clears the run bits and both outputs
  assert_evt_clears_R2: assert property (@(posedge clk) disable iff (!por_n)
    (evt && !flags_we) |=> (!run_rel && !dbg_en && !ram_we && flags_q[1:0] == 2'b00));

  // R10: trim override never falls while power-on reset is released
  assert_trim_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(flags_q[2]));

endmodule

bind nvm_boot_seq nvm_boot_seq_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .evt_button (evt_button),
  .evt_timer  (evt_timer),
  .evt_host   (evt_host),
  .flags_we   (flags_we),
  .flags_q    (flags_q),
  .nvm_re     (nvm_re),
  .ram_we     (ram_we),
  .dbg_en     (dbg_en),
  .run_rel    (run_rel)
);

// File: tb/sim_nvm_boot_seq.sv
module sim_nvm_boot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_BASE   = 16'hFE00;
  localparam int BVAR_BASE  = 16'hFFFC;
  localparam int IRAM_N     = 16;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        por_n;
  logic        evt_button, evt_timer, evt_host;
  logic        autorun;
  logic        flags_we;
  logic [2:0]  flags_wdata;
  logic [2:0]  flags_q;
  logic [15:0] nvm_addr;
  logic        nvm_re;
  logic [7:0]  nvm_rdata;
  logic        ram_we, ram_sel;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        dbg_en, run_rel;

  int checks = 0;
  int errors = 0;

  logic [7:0] setup [64];
  logic [7:0] cmem [int];
  logic [7:0] imem [int];
  int         nwr;
  int         niram;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_boot_seq u0 (
    .clk(clk), .por_n(por_n), .evt_button(evt_button), .evt_timer(evt_timer),
    .evt_host(evt_host), .autorun(autorun), .flags_we(flags_we),
    .flags_wdata(flags_wdata), .flags_q(flags_q), .nvm_addr(nvm_addr),
    .nvm_re(nvm_re), .nvm_rdata(nvm_rdata), .ram_we(ram_we), .ram_sel(ram_sel),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .dbg_en(dbg_en), .run_rel(run_rel)
  );

  function automatic logic [7:0] user_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] nvm_val(input logic [15:0] a);
    if (a >= 16'hFFC0) return setup[a[5:0]];
    return user_byte(a);
  endfunction

  // NVM model: one cycle read latency
  always @(posedge clk) begin
    if (nvm_re) nvm_rdata <= nvm_val(nvm_addr);
  end

  // RAM write monitor
  always @(negedge clk) begin
    if (ram_we) begin
      nwr++;
      if (ram_sel) begin
        imem[int'(ram_addr)] = ram_wdata;
        niram++;
      end else begin
        cmem[int'(ram_addr)] = ram_wdata;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual cycles %0d expected below %0d", WD_CYCLES, WD_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    cmem.delete();
    imem.delete();
    nwr   = 0;
    niram = 0;
  endtask

  task automatic load_setup(input logic [7:0] level, input logic [15:0] start,
                            input logic [15:0] len);
    for (int i = 0; i < 64; i++) setup[i] = 8'(i * 7 + 1);
    setup[6'h38] = level;
    setup[6'h3A] = start[7:0];
    setup[6'h3B] = start[15:8];
    setup[6'h3C] = len[7:0];
    setup[6'h3D] = len[15:8];
  endtask

  task automatic pulse(input bit b, input bit t, input bit h);
    @(negedge clk);
    evt_button = b; evt_timer = t; evt_host = h;
    @(negedge clk);
    evt_button = 1'b0; evt_timer = 1'b0; evt_host = 1'b0;
  endtask

  task automatic write_flags(input logic [2:0] v);
    @(negedge clk);
    flags_we = 1'b1; flags_wdata = v;
    @(negedge clk);
    flags_we = 1'b0; flags_wdata = '0;
  endtask

  task automatic wait_settle(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (dbg_en || run_rel) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, req, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_setup_copy(input string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (!cmem.exists(CFG_BASE + i) || cmem[CFG_BASE + i] !== setup[i]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic check_bvar(input logic [15:0] unread, input logic [7:0] lvl,
                            input int cause, input string req);
    logic [31:0] act, exp;
    act = {cmem.exists(BVAR_BASE+3) ? cmem[BVAR_BASE+3] : 8'hxx,
           cmem.exists(BVAR_BASE+2) ? cmem[BVAR_BASE+2] : 8'hxx,
           cmem.exists(BVAR_BASE+1) ? cmem[BVAR_BASE+1] : 8'hxx,
           cmem.exists(BVAR_BASE)   ? cmem[BVAR_BASE]   : 8'hxx};
    exp = {8'(cause), lvl, unread[15:8], unread[7:0]};
    chk(act === exp, req, act, exp);
  endtask

  task automatic check_user_copy(input logic [15:0] start, input int len, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] e = user_byte(16'(start + i));
      if (i < IRAM_N) begin
        if (!imem.exists(i) || imem[i] !== e) bad++;
      end else begin
        if (!cmem.exists(i - IRAM_N) || cmem[i - IRAM_N] !== e) bad++;
      end
    end
    chk(bad == 0, req, bad, 0);
  endtask

  // Scenario: power-on reset with factory level
  task automatic t_por_factory();
    load_setup(8'h00, 16'hE100, 16'd20);
    autorun = 1'b0;
    por_n = 1'b0;
    clear_log();
    repeat (4) @(negedge clk);
    chk(!run_rel && !dbg_en && !ram_we && !nvm_re, "R1 outputs in reset",
        {run_rel, dbg_en, ram_we, nvm_re}, 0);
    chk(flags_q == 3'b000, "R1 flags in reset", flags_q, 0);
    por_n = 1'b1;
    @(negedge clk);
    chk(!nvm_re && !ram_we, "R1 idle after release", {nvm_re, ram_we}, 0);
    wait_settle("R5 factory boot settles");
    check_setup_copy("R3 setup copy");
    check_bvar(16'hE100, 8'h00, 0, "R4 R5 boot vars factory por");
    chk(nwr == 68 && niram == 0, "R5 no user copy", nwr, 68);
    chk(dbg_en && !run_rel, "R5 waiting with debug", {dbg_en, run_rel}, 2'b10);
  endtask

  // Scenario: run bit B releases from wait
  task automatic t_run_bit_b();
    write_flags(3'b010);
    chk(flags_q[1] && !run_rel, "R11 not yet released", {flags_q[1], run_rel}, 2'b10);
    @(negedge clk);
    chk(run_rel == 1'b1, "R11 release one cycle later", run_rel, 1);
    repeat (6) @(negedge clk);
    chk(run_rel && dbg_en, "R11 release persists", {run_rel, dbg_en}, 2'b11);
    write_flags(3'b000);
    chk(flags_q[1] == 1'b1, "R10 write of zero ignored", flags_q, 3'b010);
  endtask

  // Scenario: button wake, user level, no auto-run
  task automatic t_button_user();
    load_setup(8'h01, 16'hE100, 16'd20);
    autorun = 1'b0;
    pulse(1'b1, 1'b0, 1'b0);
    clear_log();
    chk(flags_q[1:0] == 2'b00 && !run_rel && !dbg_en, "R2 event clears",
        {flags_q, run_rel, dbg_en}, 0);
    wait_settle("R7 user boot settles");
    check_setup_copy("R3 setup copy user");
    check_user_copy(16'hE100, 20, "R6 user image split");
    chk(nwr == 88 && niram == 16, "R6 write counts", nwr, 88);
    check_bvar(16'hE114, 8'h01, 1, "R4 R6 boot vars button");
    chk(dbg_en && !run_rel, "R7 waits after user copy", {dbg_en, run_rel}, 2'b10);
    write_flags(3'b001);
    @(negedge clk);
    chk(run_rel == 1'b1, "R11 run bit A releases", run_rel, 1);
  endtask

  // Scenario: timer wake with auto-run
  task automatic t_timer_autorun();
    load_setup(8'h5A, 16'hE200, 16'd24);
    autorun = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    clear_log();
    wait_settle("R8 autorun settles");
    chk(run_rel && !dbg_en, "R8 released without debug", {run_rel, dbg_en}, 2'b10);
    check_user_copy(16'hE200, 24, "R6 user copy autorun");
    check_bvar(16'hE218, 8'h5A, 2, "R2 R4 timer cause");
  endtask

  // Scenario: trim override beats auto-run on host reset
  task automatic t_trim_host();
    write_flags(3'b100);
    pulse(1'b0, 1'b0, 1'b1);
    clear_log();
    chk(flags_q == 3'b100, "R10 trim survives event", flags_q, 3'b100);
    wait_settle("R9 trim settles");
    chk(dbg_en && !run_rel, "R9 trim forces wait", {dbg_en, run_rel}, 2'b10);
    chk(nwr == 68 && niram == 0, "R9 no user copy under trim", nwr, 68);
    check_bvar(16'hE200, 8'h5A, 3, "R2 R9 host cause");
  endtask

  // Scenario: simultaneous events, priority of causes
  task automatic t_priority();
    pulse(1'b1, 1'b1, 1'b0);
    clear_log();
    wait_settle("R2 priority settles");
    check_bvar(16'hE200, 8'h5A, 2, "R2 timer beats button");
    pulse(1'b1, 1'b1, 1'b1);
    clear_log();
    wait_settle("R2 priority settles host");
    check_bvar(16'hE200, 8'h5A, 3, "R2 host beats timer");
  endtask

  // Scenario: power-on reset clears trim
  task automatic t_por_clears_trim();
    @(negedge clk);
    por_n = 1'b0;
    clear_log();
    @(negedge clk);
    chk(flags_q == 3'b000, "R10 por clears trim", flags_q, 0);
    por_n = 1'b1;
    wait_settle("R8 post-por autorun settles");
    chk(run_rel && !dbg_en, "R8 autorun after trim cleared", {run_rel, dbg_en}, 2'b10);
    check_bvar(16'hE218, 8'h5A, 0, "R2 R4 por cause");
  endtask

  // Scenario: zero-length user image
  task automatic t_zero_len();
    load_setup(8'h02, 16'hE300, 16'd0);
    autorun = 1'b0;
    pulse(1'b1, 1'b0, 1'b0);
    clear_log();
    wait_settle("R13 zero length settles");
    chk(nwr == 68 && niram == 0, "R13 zero length copies nothing", nwr, 68);
    check_bvar(16'hE300, 8'h02, 1, "R13 unread equals start");
    chk(dbg_en && !run_rel, "R13 R7 waits", {dbg_en, run_rel}, 2'b10);
  endtask

  // Scenario: event in the middle of loading
  task automatic t_restart();
    load_setup(8'h03, 16'hE400, 16'd30);
    autorun = 1'b0;
    pulse(1'b1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    chk(nwr > 0 && !dbg_en, "R12 load in progress", nwr, 1);
    pulse(1'b0, 1'b1, 1'b0);
    clear_log();
    wait_settle("R12 restart settles");
    chk(nwr == 98 && niram == 16, "R12 restart write count", nwr, 98);
    check_setup_copy("R12 R3 setup after restart");
    check_user_copy(16'hE400, 30, "R12 R6 user after restart");
    check_bvar(16'hE41E, 8'h03, 2, "R12 R4 boot vars after restart");
  endtask

  initial begin
    por_n = 1'b0;
    evt_button = 1'b0; evt_timer = 1'b0; evt_host = 1'b0;
    autorun = 1'b0;
    flags_we = 1'b0; flags_wdata = '0;
    nvm_rdata = '0;
    nwr = 0; niram = 0;
    t_por_factory();
    t_run_bit_b();
    t_button_user();
    t_timer_autorun();
    t_trim_host();
    t_priority();
    t_por_clears_trim();
    t_zero_len();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule